// File: doc/BRIEF.md
# Self-Timed Bus Handshake Responder

This block is the peripheral side of a self-timed expansion bus access, in which the peripheral decides how long each cycle lasts. The host marks a cycle with an active-low space select and an active-low request line. The responder answers through two open-drain lines, each modelled as a drive-low enable. The bus-latch line freezes the data on the host side of the bus. The grant line tells the host that the peripheral has finished with the cycle.

On a write, the responder captures the host data and holds the latch line low. It hands the data to local logic with a one-cycle strobe. It asserts grant once the local logic reports ready. On a read, it strobes the local logic for a value and waits for ready. It then drives the value onto the bus for at least one clock before pulling the latch line low, and only after that asserts grant.

The host may withdraw the request before grant, for example while it serves DMA. The responder then keeps the latch held and does not grant until the request returns. A monitor counts reference ticks during such an interruption and flags one that runs past the permitted limit. The select, request and direction inputs pass through two-flop synchronisers. An input change therefore reaches the handshake logic after two clocks, and the registered outputs change one clock later.

Top module: `selftimed_resp`

## Requirements
- R1: While reset is high and on release from reset, the latch enable, grant enable, data-bus enable, both local strobes and the error flag are all low.
- R2: A cycle starts when the synchronised select and request are both asserted (low) and the direction input is 1 (write). In that case the latch enable goes high, the captured bus data appears on the local write-data output, and the local write strobe is high for exactly one clock.
- R3: In a write cycle the grant enable stays low for as long as the local ready input is low. It goes high on the clock after ready is seen high while the request is asserted.
- R4: A cycle with direction 0 is a read. The local read strobe pulses for one clock. After ready, the local read data is driven with the data-bus enable high for one clock while the latch enable is still low. The latch enable then rises, and grant follows one clock later.
- R5: Grant is never raised while the synchronised request is deasserted. If ready arrives during an interruption, grant waits until the request is asserted again.
- R6: When the request is withdrawn before grant, the latch enable stays high for the whole interruption.
- R7: Grant is a one-clock pulse, raised only while the latch enable is high. After grant, the latch enable stays high until the deasserted request is seen, and then falls.
- R8: An interruption longer than STRETCH_LIMIT reference ticks (one tick every REF_DIV clocks) sets the error flag. A shorter interruption leaves it low. The flag stays set until the next cycle starts.
- R9: Deasserting select in the middle of a cycle releases the latch, grant and data-bus enables. No new cycle starts until select and request are both asserted again.
- R10: Select without request, or request without select, starts no cycle: no strobe pulses and no enable rises.
- R11: The data-bus enable is high only during a read cycle. It falls when the read cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Space select from the host, active low |
| req_n | input | 1 | Transfer request from the host, active low |
| dir_wr | input | 1 | Direction from the host: 1 write, 0 read |
| bus_din | input | DATA_W | Write data from the host |
| bus_dout | output | DATA_W | Read data towards the host |
| bus_doe | output | 1 | Drive enable for bus_dout |
| latch_oe | output | 1 | Pull the open-drain bus-latch line low |
| grant_oe | output | 1 | Pull the open-drain grant line low |
| loc_wr_stb | output | 1 | One-clock strobe: write data valid for local logic |
| loc_wr_data | output | DATA_W | Write data captured for local logic |
| loc_rd_stb | output | 1 | One-clock strobe: local logic should supply read data |
| loc_rd_data | input | DATA_W | Read data from local logic, valid with loc_ready |
| loc_ready | input | 1 | Local logic has finished with the current cycle |
| stretch_err | output | 1 | An interruption exceeded the permitted length |

## Verification
The hardest situation to reach is a host interruption that lands after the latch is held and grant is pending. Local ready then arrives in the middle of the gap, and the responder must keep the latch and hold back grant until the request returns. The bench holds ready low to park the responder in its pending state and withdraws the request there. It raises ready during the gap, and then varies the gap length on both sides of the tick limit so that the error flag is seen both staying low and being set.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_SETUP,
    ST_PEND,
    ST_GRANT,
    ST_RELEASE
  } shr_state_e;
endpackage

// File: rtl/shr_sync.sv
module shr_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] sr;
    always_ff @(posedge clk) begin
      if (rst) sr <= {2{INIT[i]}};
      else     sr <= {sr[0], d[i]};
    end
    assign q[i] = sr[1];
  end
endmodule

// File: rtl/shr_stretch_mon.sv
module shr_stretch_mon #(
  parameter int REF_DIV = 6,
  parameter int LIMIT   = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic clr,
  output logic err
);
  localparam int DIV_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam int CNT_W = $clog2(LIMIT + 2);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(REF_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT);

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = (div_q == DIV_LAST);

  // free-running reference tick
  always_ff @(posedge clk) begin
    if (rst)       div_q <= '0;
    else if (tick) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  // ticks elapsed in the current interruption
  always_ff @(posedge clk) begin
    if (rst || !active)               cnt_q <= '0;
    else if (tick && cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                                       err <= 1'b0;
    else if (clr)                                  err <= 1'b0;
    else if (active && tick && cnt_q == CNT_LAST)  err <= 1'b1;
  end

  AST_ERR_NEEDS_STRETCH: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(active)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err && !clr) |=> err); // R8
endmodule

// File: rtl/selftimed_resp.sv
module selftimed_resp
  import shr_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int REF_DIV       = 6,
  parameter int STRETCH_LIMIT = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              req_n,
  input  logic              dir_wr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              latch_oe,
  output logic              grant_oe,
  output logic              loc_wr_stb,
  output logic [DATA_W-1:0] loc_wr_data,
  output logic              loc_rd_stb,
  input  logic [DATA_W-1:0] loc_rd_data,
  input  logic              loc_ready,
  output logic              stretch_err
);
  localparam int            SYNC_W    = 3;
  localparam logic [SYNC_W-1:0] SYNC_INIT = 3'b011; // {dir, req_n, sel_n}

  logic [SYNC_W-1:0] sync_q;
  logic sel_a, req_a, wr_a, start;
  shr_state_e state_q, state_d;
  logic cyc_wr_q, cyc_wr_d;
  logic stretch_act;

  shr_sync #(.W(SYNC_W), .INIT(SYNC_INIT)) u_sync (
    .clk(clk), .rst(rst), .d({dir_wr, req_n, sel_n}), .q(sync_q)
  );

  assign sel_a = ~sync_q[0];
  assign req_a = ~sync_q[1];
  assign wr_a  =  sync_q[2];
  assign start = (state_q == ST_IDLE) && sel_a && req_a;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (start) state_d = wr_a ? ST_PEND : ST_RD_WAIT;
      ST_RD_WAIT:  if (loc_ready) state_d = ST_RD_SETUP;
      ST_RD_SETUP: state_d = ST_PEND;
      ST_PEND:     if (req_a && (loc_ready || !cyc_wr_q)) state_d = ST_GRANT;
      ST_GRANT:    state_d = ST_RELEASE;
      ST_RELEASE:  if (!req_a) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
    if (!sel_a && state_q != ST_IDLE) state_d = ST_IDLE;
  end

  assign cyc_wr_d = start ? wr_a : cyc_wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cyc_wr_q    <= 1'b0;
      latch_oe    <= 1'b0;
      grant_oe    <= 1'b0;
      bus_doe     <= 1'b0;
      bus_dout    <= '0;
      loc_wr_stb  <= 1'b0;
      loc_rd_stb  <= 1'b0;
      loc_wr_data <= '0;
    end else begin
      state_q    <= state_d;
      cyc_wr_q   <= cyc_wr_d;
      latch_oe   <= (state_d == ST_PEND) || (state_d == ST_GRANT) ||
                    (state_d == ST_RELEASE);
      grant_oe   <= (state_d == ST_GRANT);
      bus_doe    <= !cyc_wr_d && ((state_d == ST_RD_SETUP) || (state_d == ST_PEND) ||
                    (state_d == ST_GRANT) || (state_d == ST_RELEASE));
      loc_wr_stb <= start && wr_a;
      loc_rd_stb <= start && !wr_a;
      if (start && wr_a) loc_wr_data <= bus_din;
      if (state_q == ST_RD_WAIT && state_d == ST_RD_SETUP) bus_dout <= loc_rd_data;
    end
  end

  assign stretch_act = sel_a && !req_a &&
                       ((state_q == ST_RD_WAIT) || (state_q == ST_RD_SETUP) ||
                        (state_q == ST_PEND));

  shr_stretch_mon #(.REF_DIV(REF_DIV), .LIMIT(STRETCH_LIMIT)) u_mon (
    .clk(clk), .rst(rst), .active(stretch_act), .clr(start), .err(stretch_err)
  );

  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({loc_wr_stb, loc_rd_stb})); // R2
  AST_WR_STB_PULSE: assert property (@(posedge clk) disable iff (rst)
    loc_wr_stb |=> !loc_wr_stb); // R2
  AST_RD_DATA_BEFORE_LATCH: assert property (@(posedge clk) disable iff (rst)
    ($rose(latch_oe) && !cyc_wr_q) |-> $past(bus_doe)); // R4
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_oe) |-> $past(req_a)); // R5
  AST_LATCH_HELD_IN_GAP: assert property (@(posedge clk) disable iff (rst)
    (latch_oe && sel_a && !req_a && state_q == ST_PEND) |=> latch_oe); // R6
  AST_GRANT_UNDER_LATCH: assert property (@(posedge clk) disable iff (rst)
    grant_oe |-> latch_oe); // R7
  AST_GRANT_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    grant_oe |=> !grant_oe); // R7
  AST_LATCH_FALL_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    $fell(latch_oe) |-> ($past(!req_a) || $past(!sel_a))); // R7
  AST_DOE_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> !cyc_wr_q); // R11
endmodule

// File: tb/selftimed_resp_tb.sv
module selftimed_resp_tb;
  localparam int DW = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic sel_n = 1'b1, req_n = 1'b1, dir_wr = 1'b0, loc_ready = 1'b0;
  logic [DW-1:0] bus_din = '0, rd_val = '0;
  logic [DW-1:0] bus_dout, loc_wr_data;
  logic bus_doe, latch_oe, grant_oe, loc_wr_stb, loc_rd_stb, stretch_err;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  selftimed_resp #(.DATA_W(DW), .REF_DIV(2), .STRETCH_LIMIT(15)) u_dut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .req_n(req_n), .dir_wr(dir_wr),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .latch_oe(latch_oe), .grant_oe(grant_oe), .loc_wr_stb(loc_wr_stb),
    .loc_wr_data(loc_wr_data), .loc_rd_stb(loc_rd_stb), .loc_rd_data(rd_val),
    .loc_ready(loc_ready), .stretch_err(stretch_err)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [DW-1:0] d, int rdy_delay);
    loc_ready = (rdy_delay == 0);
    bus_din = d; dir_wr = 1'b1; sel_n = 1'b0; req_n = 1'b0;
    step(3);
    chk("R2 latch on", latch_oe, 1);
    chk("R2 wr strobe", loc_wr_stb, 1);
    chk("R2 wr data", loc_wr_data, d);
    chk("R11 no doe on write", bus_doe, 0);
    if (rdy_delay > 0) begin
      step(rdy_delay);
      chk("R3 grant waits ready", grant_oe, 0);
      loc_ready = 1'b1;
    end
    step(1);
    chk("R3 grant after ready", grant_oe, 1);
    chk("R2 strobe one clock", loc_wr_stb, 0);
    step(1);
    chk("R7 grant one clock", grant_oe, 0);
    chk("R7 latch held", latch_oe, 1);
    req_n = 1'b1;
    step(2);
    chk("R7 latch until req seen", latch_oe, 1);
    step(1);
    chk("R7 latch released", latch_oe, 0);
    sel_n = 1'b1;
    step(3);
  endtask

  task automatic do_read(logic [DW-1:0] d);
    loc_ready = 1'b1; rd_val = d;
    dir_wr = 1'b0; sel_n = 1'b0; req_n = 1'b0;
    step(3);
    chk("R4 rd strobe", loc_rd_stb, 1);
    chk("R4 no latch yet", latch_oe, 0);
    step(1);
    chk("R4 data driven", bus_doe, 1);
    chk("R4 data value", bus_dout, d);
    chk("R4 latch after data", latch_oe, 0);
    chk("R4 rd strobe one clock", loc_rd_stb, 0);
    step(1);
    chk("R4 latch on", latch_oe, 1);
    chk("R4 grant after latch", grant_oe, 0);
    step(1);
    chk("R4 grant", grant_oe, 1);
    step(1);
    chk("R7 grant one clock", grant_oe, 0);
    chk("R11 doe held", bus_doe, 1);
    req_n = 1'b1;
    step(3);
    chk("R11 doe released", bus_doe, 0);
    chk("R7 latch released", latch_oe, 0);
    sel_n = 1'b1;
    step(3);
  endtask

  // write cycle interrupted for gap clocks with ready raised mid-gap
  task automatic do_gap(int gap, logic exp_err);
    loc_ready = 1'b0; bus_din = 8'h5A; dir_wr = 1'b1; sel_n = 1'b0; req_n = 1'b0;
    step(3);
    chk("R8 err cleared at start", stretch_err, 0);
    req_n = 1'b1;
    step(3);
    chk("R6 latch in gap", latch_oe, 1);
    loc_ready = 1'b1;
    step(gap);
    chk("R5 no grant in gap", grant_oe, 0);
    chk("R6 latch still held", latch_oe, 1);
    chk("R8 err vs gap length", stretch_err, exp_err);
    req_n = 1'b0;
    step(3);
    chk("R5 grant after req back", grant_oe, 1);
    step(1);
    req_n = 1'b1;
    step(3);
    chk("R7 latch released", latch_oe, 0);
    chk("R8 err holds to next start", stretch_err, exp_err);
    sel_n = 1'b1;
    step(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog R1-all actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 latch in reset", latch_oe, 0);
    chk("R1 grant in reset", grant_oe, 0);
    rst = 1'b0;
    step(2);
    chk("R1 doe", bus_doe, 0);
    chk("R1 strobes", {loc_wr_stb, loc_rd_stb}, 0);
    chk("R1 err", stretch_err, 0);

    for (int i = 0; i < 8; i++) begin
      do_write(DW'(i * 37 + 5), i % 3);
      do_read(DW'(i * 53 + 1));
    end

    do_gap(6, 1'b0);
    do_gap(20, 1'b0);
    do_gap(60, 1'b1);
    do_gap(4, 1'b0);

    // R9 abort by select
    loc_ready = 1'b0; dir_wr = 1'b1; sel_n = 1'b0; req_n = 1'b0;
    step(3);
    chk("R9 cycle running", latch_oe, 1);
    sel_n = 1'b1;
    step(3);
    chk("R9 latch released", latch_oe, 0);
    chk("R9 grant released", grant_oe, 0);
    for (int k = 0; k < 4; k++) begin
      step(1);
      chk("R9 no restart", {latch_oe, loc_wr_stb, loc_rd_stb}, 0);
    end
    req_n = 1'b1;
    step(3);

    // R10 half-asserted starts
    loc_ready = 1'b1; sel_n = 1'b0; req_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      step(1);
      chk("R10 select only", {latch_oe, bus_doe, loc_wr_stb, loc_rd_stb}, 0);
    end
    sel_n = 1'b1; req_n = 1'b0;
    for (int k = 0; k < 6; k++) begin
      step(1);
      chk("R10 request only", {latch_oe, bus_doe, loc_wr_stb, loc_rd_stb}, 0);
    end
    req_n = 1'b1;
    step(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule